// File: doc/BRIEF.md
# Pulse-Sync Serial I/Q Deserializer

This block takes the one-bit serial baseband stream of a satellite-navigation RF front end and rebuilds complex samples from it. The front end sends a data bit and a framing pulse on every rising edge of its own sample clock, which runs at 8.192 MHz. Each group of four consecutive bits carries one complex sample: the in-phase sign, the in-phase magnitude, the quadrature sign and then the quadrature magnitude. A one-clock framing pulse marks the first bit of every group. The block tracks the group position, emits one packed 4-bit sample per group with a one-cycle valid strobe, and so delivers 2.048 Msps.

The block stays silent after reset until it sees the first framing pulse. It then reports lock. A framing pulse in the wrong place, or a missing one, raises a one-cycle error flag and realigns the framing. Two signed outputs give the value of each component (±1 or ±3), decoded from the current sample. A free-running sample counter steps on every strobe, so a downstream consumer can spot dropped samples. Everything runs in the front-end clock domain.

Top module: `iq_deser`

## Requirements
- R1: While rst_ni is low, sample_o, valid_o, locked_o, sync_err_o and sample_cnt_o are all zero.
- R2: After reset, valid_o and locked_o stay low until a clock edge samples sync_i high. locked_o is high from the cycle after that edge on.
- R3: sample_o packs the four bits of a group as bit3 = in-phase sign (the bit sampled with sync_i high), bit2 = in-phase magnitude, bit1 = quadrature sign, bit0 = quadrature magnitude.
- R4: valid_o is high for exactly one cycle. That cycle directly follows the edge that samples the quadrature-magnitude bit (the fourth bit of the group). With a clean stream this gives one strobe every four clocks.
- R5: If a locked block samples sync_i high at any bit other than the first of a group, sync_err_o is high in the next cycle. The partial group is discarded, produces no strobe, and a new group starts with that bit.
- R6: If a locked block samples sync_i low where a group's first bit is due, sync_err_o is high in the next cycle and locked_o goes low in the same cycle. No strobe follows until sync_i is next sampled high.
- R7: i_val_o and q_val_o are 3-bit two's-complement values decoded from sample_o: sign 0 with magnitude 0 or 1 gives +1 or +3, and sign 1 with magnitude 0 or 1 gives −1 or −3.
- R8: sample_cnt_o increases by one, modulo 2^CNT_W, on the same edge that raises valid_o. Otherwise it holds its value.
- R9: sample_o holds its value in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Front-end sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial baseband bit |
| sync_i | input | 1 | Framing pulse, high on the first bit of each group |
| sample_o | output | 4 | Packed complex sample {I sign, I mag, Q sign, Q mag} |
| valid_o | output | 1 | One-cycle strobe for a new sample_o |
| locked_o | output | 1 | Framing acquired |
| sync_err_o | output | 1 | One-cycle framing error flag |
| i_val_o | output | 3 | Signed in-phase value (±1, ±3) |
| q_val_o | output | 3 | Signed quadrature value (±1, ±3) |
| sample_cnt_o | output | CNT_W | Count of strobes, wrapping |

## Verification
Every registered result is due exactly one clock after the edge that samples its input bit. sample_o, valid_o and sample_cnt_o follow the fourth bit of a group. sync_err_o follows the offending bit, and locked_o follows the first framing pulse or the missing pulse. The decoded values follow sample_o in the same cycle. The bench feeds each bit to its behavioural model in the same step in which it drives that bit. It compares the model with the outputs at the next falling edge, which is half a clock after the edge that settles them, so every result is checked in the cycle it is due.

// File: rtl/iq_deser_pkg.sv
package iq_deser_pkg;
  localparam int unsigned FRAME_LEN = 4;
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);
  localparam int unsigned VAL_W     = 3;

  typedef logic [FRAME_LEN-1:0] sample_t;
  typedef logic signed [VAL_W-1:0] val_t;

  // sign/magnitude pair -> odd signed value
  function automatic val_t sm_to_val(input logic sign, input logic mag);
    val_t v;
    v = mag ? val_t'(3) : val_t'(1);
    return sign ? -v : v;
  endfunction
endpackage

// File: rtl/iq_frame_ctrl.sv
module iq_frame_ctrl
  import iq_deser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic last_o,
  output logic locked_o,
  output logic sync_err_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;
  logic             locked_q;
  logic             err_q;
  logic             first_due;

  assign first_due = (pos_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= locked_q && (sync_i != first_due);
      if (sync_i) begin
        locked_q <= 1'b1;
        pos_q    <= POS_W'(1);
      end else if (locked_q) begin
        if (first_due) begin
          locked_q <= 1'b0;
        end else begin
          pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + POS_W'(1);
        end
      end
    end
  end

  assign last_o     = locked_q && !sync_i && (pos_q == LAST_POS);
  assign locked_o   = locked_q;
  assign sync_err_o = err_q;

  AST_MISSING_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && first_due && !sync_i) |=> (sync_err_o && !locked_o)); // R6
  AST_EXTRA_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !first_due && sync_i) |=> (sync_err_o && locked_o)); // R5
  AST_NO_LOCK_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |=> !sync_err_o); // R2
endmodule

// File: rtl/iq_shift_pack.sv
module iq_shift_pack
  import iq_deser_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             last_i,
  output sample_t          sample_o,
  output logic             valid_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [FRAME_LEN-2:0] sh_q;
  sample_t              sample_q;
  logic                 valid_q;
  logic [CNT_W-1:0]     cnt_q;

  // shift every cycle: the three bits before the last one are always the group's own
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      sample_q <= '0;
      valid_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sh_q    <= {sh_q[FRAME_LEN-3:0], data_i};
      valid_q <= last_i;
      if (last_i) begin
        sample_q <= {sh_q, data_i};
        cnt_q    <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;
  assign cnt_o    = cnt_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(sample_o)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(cnt_o)); // R8
endmodule

// File: rtl/iq_sm_decode.sv
module iq_sm_decode
  import iq_deser_pkg::*;
#(
  parameter int unsigned NUM_COMP = FRAME_LEN / 2
) (
  input  sample_t                      sample_i,
  output logic [NUM_COMP*VAL_W-1:0]    val_o
);
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    localparam int unsigned SB = FRAME_LEN - 1 - 2*c;
    val_t v;
    assign v = sm_to_val(sample_i[SB], sample_i[SB-1]);
    assign val_o[(NUM_COMP-1-c)*VAL_W +: VAL_W] = v;

    always_comb begin
      AST_DEC_ODD: assert (v[0] == 1'b1 && v[VAL_W-1] == sample_i[SB]); // R7
    end
  end
endmodule

// File: rtl/iq_deser.sv
module iq_deser
  import iq_deser_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic             sync_i,
  output logic [3:0]       sample_o,
  output logic             valid_o,
  output logic             locked_o,
  output logic             sync_err_o,
  output logic [2:0]       i_val_o,
  output logic [2:0]       q_val_o,
  output logic [CNT_W-1:0] sample_cnt_o
);
  localparam int unsigned NUM_COMP = FRAME_LEN / 2;

  logic                        last;
  sample_t                     sample;
  logic [NUM_COMP*VAL_W-1:0]   vals;

  iq_frame_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .last_o     (last),
    .locked_o   (locked_o),
    .sync_err_o (sync_err_o)
  );

  iq_shift_pack #(.CNT_W(CNT_W)) i_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .last_i   (last),
    .sample_o (sample),
    .valid_o  (valid_o),
    .cnt_o    (sample_cnt_o)
  );

  iq_sm_decode #(.NUM_COMP(NUM_COMP)) i_dec (
    .sample_i (sample),
    .val_o    (vals)
  );

  assign sample_o = sample;
  assign i_val_o  = vals[2*VAL_W-1:VAL_W];
  assign q_val_o  = vals[VAL_W-1:0];

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(locked_o)); // R2
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (sample_cnt_o != $past(sample_cnt_o))); // R8
endmodule

// File: tb/test_iq_deser.sv
module test_iq_deser;
  localparam time CLK_PERIOD = 122ns;
  localparam int  CNT_W      = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data = 1'b0;
  logic sync = 1'b0;
  logic [3:0] sample;
  logic valid, locked, sync_err;
  logic [2:0] i_val, q_val;
  logic [CNT_W-1:0] cnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  int        m_pos = -1;
  bit        m_q[$];
  logic [3:0] e_sample = '0;
  bit        e_valid = 0, e_err = 0, e_locked = 0;
  int        e_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_deser #(.CNT_W(CNT_W)) i_iq_deser (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data), .sync_i(sync),
    .sample_o(sample), .valid_o(valid), .locked_o(locked),
    .sync_err_o(sync_err), .i_val_o(i_val), .q_val_o(q_val),
    .sample_cnt_o(cnt)
  );

  function automatic int dec(input logic s, input logic m);
    int v = m ? 3 : 1;
    return s ? -v : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk("R3 sample", int'(sample), int'(e_sample));
    chk("R4 valid", int'(valid), int'(e_valid));
    chk("R2 locked", int'(locked), int'(e_locked));
    chk("R5/R6 sync_err", int'(sync_err), int'(e_err));
    chk("R8 count", int'(cnt), e_cnt);
    chk("R7 i_val", int'($signed(i_val)), dec(e_sample[3], e_sample[2]));
    chk("R7 q_val", int'($signed(q_val)), dec(e_sample[1], e_sample[0]));
  endtask

  task automatic model(input bit d, input bit s);
    e_valid = 0;
    e_err   = 0;
    if (m_pos >= 0 && (s != (m_pos == 0))) e_err = 1;
    if (s) begin
      m_q = {d};
      m_pos = 1;
      e_locked = 1;
    end else if (m_pos == 0) begin
      m_q.delete();
      m_pos = -1;
      e_locked = 0;
    end else if (m_pos > 0) begin
      m_q.push_back(d);
      if (m_q.size() == 4) begin
        e_sample = {m_q[0], m_q[1], m_q[2], m_q[3]};  // R3 packing
        e_valid  = 1;
        e_cnt    = (e_cnt + 1) % (1 << CNT_W);
        m_q.delete();
        m_pos = 0;
      end else begin
        m_pos++;
      end
    end
  endtask

  task automatic drive(input bit d, input bit s);
    @(negedge clk);
    compare();
    data = d;
    sync = s;
    model(d, s);
  endtask

  task automatic group(input logic [3:0] nib);
    drive(nib[3], 1);
    drive(nib[2], 0);
    drive(nib[1], 0);
    drive(nib[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs under reset
    chk("R1 sample", int'(sample), 0);
    chk("R1 valid", int'(valid), 0);
    chk("R1 locked", int'(locked), 0);
    chk("R1 sync_err", int'(sync_err), 0);
    chk("R1 count", int'(cnt), 0);
    rst_ni = 1'b1;
    // R2: data without framing pulse
    for (int k = 0; k < 9; k++) drive(k[0], 0);
    // R3/R4/R7/R8: all nibble values, clean stream, counter wraps
    for (int k = 0; k < 16; k++) group(4'(k));
    for (int k = 0; k < 6; k++) group(4'(15 - 3*k));
    // R5: pulse one bit into a group, then again at bit three
    drive(1, 1); drive(0, 1);
    drive(1, 0); drive(1, 1);
    drive(0, 0); drive(1, 0); drive(0, 0);
    group(4'hC);
    // R6: missing pulse loses lock; idle data must not produce strobes
    drive(1, 0);
    for (int k = 0; k < 7; k++) drive(~k[0], 0);
    group(4'h9);
    group(4'h6);
    // R5: pulse at the last bit position
    drive(0, 1); drive(1, 0); drive(1, 0); drive(1, 1);
    drive(1, 0); drive(0, 0); drive(1, 0);
    // R9: after a strobe, a gap with lock lost keeps sample stable
    for (int k = 0; k < 5; k++) drive(k[1], 0);
    for (int k = 0; k < 8; k++) group(4'(7*k + 2));
    drive(0, 0);
    drive(0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule